// File: doc/BRIEF.md
# Receive Delimiter Search and Header Validation

This block sits behind the receive descrambler. Once the descrambler reports that it has initialised, the block slides a 16-bit window over the incoming bits and looks for the frame delimiter in either of two orientations. The orientation it finds tells it whether the packet uses the long or the short preamble. A budget of received bits bounds the search. The block picks that budget from the polarity of the sync bits, because long-preamble sync is all ones and short-preamble sync is all zeros.

After the delimiter, the block collects a 48-bit header. The header holds a rate byte, a service byte, a 16-bit length and a 16-bit check value. The block runs a CRC over the first 32 bits as they arrive. On a match it presents the fields with a ready level. On a mismatch, or when the search budget runs out, it raises a sticky error flag and falls back to waiting for the next acquisition.

Top module: `hdrx_hdr_checker`

## Requirements
- R1: `hdr_ready_o` never rises unless a delimiter was matched after the most recent `scr_ready_i` pulse. Bits that arrive while the block is waiting for acquisition are ignored.
- R2: A one-cycle `scr_ready_i` pulse starts a new search. It clears `hdr_ready_o`, empties the window and zeroes the bit budget counter. A bit presented in the same cycle as the pulse is dropped.
- R3: The delimiter is matched when the last 16 valid bits equal the `LONG_DLM` pattern (default 16'h05CF, most significant bit received first), which sets `short_mode_o` to 0, or equal the bit reverse of that pattern (default 16'hF3A0), which sets `short_mode_o` to 1. A match needs at least 16 bits received since the pulse.
- R4: Each valid bit in the search counts toward the budget. If the N-th bit does not complete a match, `sfd_tmo_o` is set and the block returns to waiting. N is `long_limit_i` when that bit is 1 and `short_limit_i` when it is 0.
- R5: Header bits arrive in three groups. Bits 0 to 7 are the rate byte and bits 8 to 15 are the service byte, each least significant bit first. Bits 16 to 31 are the length, least significant bit first. Bits 32 to 47 are the check value, bit 15 first.
- R6: The expected check value is the ones complement of a CRC register. The register is preset to all ones and steps once per bit over the 32 protected bits, in arrival order, with polynomial x^16+x^12+x^5+1 (feedback = register bit 15 XOR incoming bit).
- R7: When the check value matches, `hdr_ready_o` is 1 from the edge that takes the 48th header bit. It stays 1, with `length_o` and the other field outputs held, until the next `scr_ready_i` pulse.
- R8: When the check value does not match, `crc_err_o` is set, `hdr_ready_o` is 0 and the block returns to waiting. Further bits have no effect until a new pulse.
- R9: `crc_err_o` and `sfd_tmo_o` stay set until `err_clr_i` is high at a clock edge. A flag being set in that same cycle takes priority over the clear.
- R10: `rate_code_o` maps the captured rate byte as follows: 0x0A to 0, 0x14 to 1, 0x37 to 2, 0x6E to 3, and any other value to 4.
- R11: `len_ext_o` reflects bit 7 of the captured service byte. `locked_osc_o` reflects bit 2. `service_o` carries the whole byte.
- R12: After reset all outputs are 0, except `rate_code_o`, which reads 4.
- R13: A cycle with `bit_valid_i` low advances neither the search budget nor the header position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scr_ready_i | input | 1 | Descrambler initialised; one-cycle pulse that starts a search |
| bit_valid_i | input | 1 | Strobe qualifying `bit_i` |
| bit_i | input | 1 | Descrambled received bit |
| long_limit_i | input | TMO_W | Search budget in bits when sync polarity is one |
| short_limit_i | input | TMO_W | Search budget in bits when sync polarity is zero |
| err_clr_i | input | 1 | Clears both sticky error flags |
| hdr_ready_o | output | 1 | Header accepted; fields valid |
| short_mode_o | output | 1 | 1 when the reversed delimiter was found |
| rate_code_o | output | 3 | Decoded rate selection |
| service_o | output | 8 | Captured service byte |
| len_ext_o | output | 1 | Length extension flag from the service byte |
| locked_osc_o | output | 1 | Shared-oscillator flag from the service byte |
| length_o | output | 16 | Captured length field |
| crc_err_o | output | 1 | Sticky header check failure |
| sfd_tmo_o | output | 1 | Sticky delimiter search timeout |

## Verification
The properties assume that `scr_ready_i` is a single-cycle pulse and that the bit budgets are at least 1. The stimulus drives exactly that: each search is opened by a one-cycle pulse, and the budgets are fixed non-zero values. The random packets keep their sync length well below the budget so that the timeout path is reached only in the directed cases. The `bit_valid_i` strobe is gapped at random, which exercises the hold behaviour of both counters.

// File: rtl/hdrx_pkg.sv
package hdrx_pkg;

    localparam int DLM_W  = 16;
    localparam int FLD_W  = 32;
    localparam int CRC_W  = 16;
    localparam int HDR_W  = FLD_W + CRC_W;
    localparam int HCNT_W = $clog2(HDR_W);

    typedef enum logic [1:0] {
        ST_ACQ,
        ST_SEARCH,
        ST_HDR
    } hdrx_st_e;

    localparam logic [7:0] SIG_R0 = 8'h0A;
    localparam logic [7:0] SIG_R1 = 8'h14;
    localparam logic [7:0] SIG_R2 = 8'h37;
    localparam logic [7:0] SIG_R3 = 8'h6E;
    localparam logic [2:0] RATE_UNKNOWN = 3'd4;

endpackage

// File: rtl/hdrx_dlm_window.sv
module hdrx_dlm_window #(
    parameter int               W        = 16,
    parameter logic [W-1:0]     LONG_PAT = 16'h05CF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic hit_long_o,
    output logic hit_short_o
);
    localparam int FW = $clog2(W + 1);
    localparam logic [FW-1:0] FULL_AT = FW'(W - 1);

    logic [W-1:0]  short_pat;
    logic [W-1:0]  win_d, win_q;
    logic [FW-1:0] fill_d, fill_q;
    logic [W-1:0]  win_nx;
    logic          full;

    for (genvar g = 0; g < W; g++) begin : g_rev
        assign short_pat[g] = LONG_PAT[W-1-g];
    end

    assign win_nx = {win_q[W-2:0], bit_i};
    assign full   = (fill_q == FULL_AT);

    always_comb begin
        win_d  = win_q;
        fill_d = fill_q;
        if (clr_i) begin
            win_d  = '0;
            fill_d = '0;
        end else if (shift_i) begin
            win_d = win_nx;
            if (!full) fill_d = fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            fill_q <= '0;
        end else begin
            win_q  <= win_d;
            fill_q <= fill_d;
        end
    end

    assign hit_long_o  = shift_i && !clr_i && full && (win_nx == LONG_PAT);
    assign hit_short_o = shift_i && !clr_i && full && (win_nx == short_pat);

endmodule

// File: rtl/hdrx_crc_step.sv
module hdrx_crc_step #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

endmodule

// File: rtl/hdrx_rate_map.sv
module hdrx_rate_map
    import hdrx_pkg::*;
(
    input  logic [7:0] sig_i,
    output logic [2:0] code_o
);
    always_comb begin
        unique case (sig_i)
            SIG_R0:  code_o = 3'd0;
            SIG_R1:  code_o = 3'd1;
            SIG_R2:  code_o = 3'd2;
            SIG_R3:  code_o = 3'd3;
            default: code_o = RATE_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/hdrx_hdr_checker.sv
module hdrx_hdr_checker
    import hdrx_pkg::*;
#(
    parameter int                 TMO_W    = 16,
    parameter logic [DLM_W-1:0]   LONG_DLM = 16'h05CF,
    parameter logic [CRC_W-1:0]   CRC_POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scr_ready_i,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    input  logic [TMO_W-1:0] long_limit_i,
    input  logic [TMO_W-1:0] short_limit_i,
    input  logic             err_clr_i,
    output logic             hdr_ready_o,
    output logic             short_mode_o,
    output logic [2:0]       rate_code_o,
    output logic [7:0]       service_o,
    output logic             len_ext_o,
    output logic             locked_osc_o,
    output logic [15:0]      length_o,
    output logic             crc_err_o,
    output logic             sfd_tmo_o
);
    localparam logic [HCNT_W-1:0] LAST_FLD = HCNT_W'(FLD_W - 1);
    localparam logic [HCNT_W-1:0] LAST_HDR = HCNT_W'(HDR_W - 1);

    typedef struct packed {
        hdrx_st_e           st;
        logic [TMO_W-1:0]   cnt;
        logic               short_mode;
        logic [HCNT_W-1:0]  hcnt;
        logic [FLD_W-1:0]   fld;
        logic [CRC_W-1:0]   crc_calc;
        logic [CRC_W-1:0]   crc_rx;
        logic               ready;
        logic [7:0]         sig;
        logic [7:0]         svc;
        logic [15:0]        len;
        logic               crc_err;
        logic               tmo;
    } hdrx_state_t;

    hdrx_state_t s_d, s_q;

    logic             win_clr, win_shift;
    logic             hit_long, hit_short;
    logic [CRC_W-1:0] crc_nx;
    logic [CRC_W-1:0] crc_rx_nx;
    logic [TMO_W-1:0] cnt_nx;
    logic [TMO_W-1:0] limit_sel;

    hdrx_dlm_window #(
        .W        (DLM_W),
        .LONG_PAT (LONG_DLM)
    ) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (win_clr),
        .shift_i     (win_shift),
        .bit_i       (bit_i),
        .hit_long_o  (hit_long),
        .hit_short_o (hit_short)
    );

    hdrx_crc_step #(
        .W    (CRC_W),
        .POLY (CRC_POLY)
    ) u_crc (
        .crc_i (s_q.crc_calc),
        .bit_i (bit_i),
        .crc_o (crc_nx)
    );

    hdrx_rate_map u_rate (
        .sig_i  (s_q.sig),
        .code_o (rate_code_o)
    );

    assign crc_rx_nx = {s_q.crc_rx[CRC_W-2:0], bit_i};
    assign cnt_nx    = s_q.cnt + 1'b1;
    assign limit_sel = bit_i ? long_limit_i : short_limit_i;

    always_comb begin
        s_d       = s_q;
        win_clr   = 1'b0;
        win_shift = 1'b0;

        if (err_clr_i) begin
            s_d.crc_err = 1'b0;
            s_d.tmo     = 1'b0;
        end

        if (scr_ready_i) begin
            s_d.st    = ST_SEARCH;
            s_d.cnt   = '0;
            s_d.ready = 1'b0;
            win_clr   = 1'b1;
        end else if (bit_valid_i) begin
            unique case (s_q.st)
                ST_SEARCH: begin
                    win_shift = 1'b1;
                    s_d.cnt   = cnt_nx;
                    if (hit_long || hit_short) begin
                        s_d.st         = ST_HDR;
                        s_d.short_mode = hit_short && !hit_long;
                        s_d.hcnt       = '0;
                        s_d.crc_calc   = '1;
                    end else if (cnt_nx == limit_sel) begin
                        s_d.tmo = 1'b1;
                        s_d.st  = ST_ACQ;
                    end
                end
                ST_HDR: begin
                    s_d.hcnt = s_q.hcnt + 1'b1;
                    if (s_q.hcnt <= LAST_FLD) begin
                        s_d.fld      = {bit_i, s_q.fld[FLD_W-1:1]};
                        s_d.crc_calc = crc_nx;
                    end else begin
                        s_d.crc_rx = crc_rx_nx;
                    end
                    if (s_q.hcnt == LAST_HDR) begin
                        s_d.st = ST_ACQ;
                        if (crc_rx_nx == ~s_q.crc_calc) begin
                            s_d.ready = 1'b1;
                            s_d.sig   = s_q.fld[7:0];
                            s_d.svc   = s_q.fld[15:8];
                            s_d.len   = s_q.fld[31:16];
                        end else begin
                            s_d.ready   = 1'b0;
                            s_d.crc_err = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_ACQ, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign hdr_ready_o  = s_q.ready;
    assign short_mode_o = s_q.short_mode;
    assign service_o    = s_q.svc;
    assign len_ext_o    = s_q.svc[7];
    assign locked_osc_o = s_q.svc[2];
    assign length_o     = s_q.len;
    assign crc_err_o    = s_q.crc_err;
    assign sfd_tmo_o    = s_q.tmo;

endmodule

// File: rtl/hdrx_hdr_check_sva.sv
module hdrx_hdr_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        scr_ready_i,
    input logic        bit_valid_i,
    input logic        err_clr_i,
    input logic        hdr_ready_o,
    input logic        short_mode_o,
    input logic [2:0]  rate_code_o,
    input logic [15:0] length_o,
    input logic        crc_err_o,
    input logic        sfd_tmo_o
);
    // R1
    ready_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_ready_o) |-> $past(bit_valid_i) && !$past(scr_ready_i));

    // R2
    pulse_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scr_ready_i |=> !hdr_ready_o);

    // R4
    tmo_without_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sfd_tmo_o) |-> !hdr_ready_o);

    // R7
    fields_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready_o && $past(hdr_ready_o) |-> $stable(length_o) && $stable(short_mode_o));

    // R8
    crc_err_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err_o) |-> !hdr_ready_o);

    // R9
    crc_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_o && !err_clr_i |=> crc_err_o);

    // R9
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfd_tmo_o && !err_clr_i |=> sfd_tmo_o);

    // R10
    rate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_code_o <= 3'd4);

    // R13
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid_i && !scr_ready_i && !err_clr_i |=>
            $stable(hdr_ready_o) && $stable(crc_err_o) && $stable(sfd_tmo_o));

endmodule

bind hdrx_hdr_checker hdrx_hdr_check_sva u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scr_ready_i  (scr_ready_i),
    .bit_valid_i  (bit_valid_i),
    .err_clr_i    (err_clr_i),
    .hdr_ready_o  (hdr_ready_o),
    .short_mode_o (short_mode_o),
    .rate_code_o  (rate_code_o),
    .length_o     (length_o),
    .crc_err_o    (crc_err_o),
    .sfd_tmo_o    (sfd_tmo_o)
);

// File: tb/hdrx_hdr_checker_tb.sv
module hdrx_hdr_checker_tb;

    localparam logic [15:0] LPAT = 16'h05CF;
    localparam logic [15:0] SPAT = 16'hF3A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scr_ready_i = 1'b0;
    logic        bit_valid_i = 1'b0;
    logic        bit_i = 1'b0;
    logic [15:0] long_limit_i = 16'd300;
    logic [15:0] short_limit_i = 16'd300;
    logic        err_clr_i = 1'b0;
    logic        hdr_ready_o, short_mode_o, len_ext_o, locked_osc_o;
    logic        crc_err_o, sfd_tmo_o;
    logic [2:0]  rate_code_o;
    logic [7:0]  service_o;
    logic [15:0] length_o;

    int checks = 0;
    int failures = 0;
    bit use_gaps = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hdrx_hdr_checker u_dut (
        .clk(clk), .rst_n(rst_n), .scr_ready_i(scr_ready_i),
        .bit_valid_i(bit_valid_i), .bit_i(bit_i),
        .long_limit_i(long_limit_i), .short_limit_i(short_limit_i),
        .err_clr_i(err_clr_i), .hdr_ready_o(hdr_ready_o),
        .short_mode_o(short_mode_o), .rate_code_o(rate_code_o),
        .service_o(service_o), .len_ext_o(len_ext_o),
        .locked_osc_o(locked_osc_o), .length_o(length_o),
        .crc_err_o(crc_err_o), .sfd_tmo_o(sfd_tmo_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_fcs(input logic [31:0] hv);
        logic [15:0] r = 16'hFFFF;
        for (int i = 0; i < 32; i++) begin
            logic top = r[15] ^ hv[i];
            r = r << 1;
            if (top) begin
                r[0]  = ~r[0];
                r[5]  = ~r[5];
                r[12] = ~r[12];
            end
        end
        return ~r;
    endfunction

    function automatic logic [2:0] ref_rate(input logic [7:0] s);
        if (s == 8'h0A) return 3'd0;
        if (s == 8'h14) return 3'd1;
        if (s == 8'h37) return 3'd2;
        if (s == 8'h6E) return 3'd3;
        return 3'd4;
    endfunction

    task automatic send_bit(input logic b);
        if (use_gaps) begin
            int gap = $urandom % 4;
            if (gap == 0) repeat (1 + $urandom % 3) @(negedge clk);
        end
        @(negedge clk);
        bit_valid_i = 1'b1;
        bit_i = b;
        @(negedge clk);
        bit_valid_i = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk);
        scr_ready_i = 1'b1;
        @(negedge clk);
        scr_ready_i = 1'b0;
    endtask

    task automatic clear_errs();
        @(negedge clk);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
    endtask

    task automatic send_hdr(input logic [7:0] sig, input logic [7:0] svc,
                            input logic [15:0] len, input bit bad);
        logic [31:0] hv = {len, svc, sig};
        logic [15:0] c = ref_fcs(hv);
        if (bad) c = c ^ (16'h1 << ($urandom % 16));
        for (int i = 0; i < 32; i++) send_bit(hv[i]);
        for (int i = 15; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_packet(input bit shrt, input int sync_len,
                               input logic [7:0] sig, input logic [7:0] svc,
                               input logic [15:0] len, input bit bad);
        logic [15:0] p = shrt ? SPAT : LPAT;
        pulse_ready();
        for (int i = 0; i < sync_len; i++) send_bit(!shrt);
        for (int i = 15; i >= 0; i--) send_bit(p[i]);
        send_hdr(sig, svc, len, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(!hdr_ready_o && !crc_err_o && !sfd_tmo_o && !short_mode_o, "R12",
            "flags after reset", {hdr_ready_o, crc_err_o, sfd_tmo_o, short_mode_o}, 0);
        chk(rate_code_o == 3'd4 && length_o == 0 && service_o == 0, "R12",
            "fields after reset", {rate_code_o, length_o}, {3'd4, 16'd0});

        // R1 bits without a start pulse are ignored
        for (int i = 15; i >= 0; i--) send_bit(LPAT[i]);
        send_hdr(8'h14, 8'h00, 16'h0100, 1'b0);
        chk(!hdr_ready_o, "R1", "ready without search", hdr_ready_o, 0);

        // R5 R7 R3 directed long packet
        send_packet(1'b0, 40, 8'h6E, 8'h84, 16'hBEEF, 1'b0);
        chk(hdr_ready_o, "R7", "ready after good long header", hdr_ready_o, 1);
        chk(!short_mode_o, "R3", "long mode", short_mode_o, 0);
        chk(length_o == 16'hBEEF, "R5", "length", length_o, 16'hBEEF);
        chk(rate_code_o == 3'd3, "R10", "rate code 0x6E", rate_code_o, 3);
        chk(len_ext_o && locked_osc_o && service_o == 8'h84, "R11",
            "service flags", {len_ext_o, locked_osc_o, service_o}, {2'b11, 8'h84});
        repeat (20) @(negedge clk);
        chk(hdr_ready_o && length_o == 16'hBEEF, "R7", "ready held", hdr_ready_o, 1);
        pulse_ready();
        chk(!hdr_ready_o, "R2", "pulse clears ready", hdr_ready_o, 0);

        // R8 corrupted check value, then ignored bits
        send_packet(1'b1, 20, 8'h0A, 8'h00, 16'h0042, 1'b1);
        chk(crc_err_o && !hdr_ready_o, "R8", "crc error flag",
            {crc_err_o, hdr_ready_o}, 2'b10);
        for (int i = 15; i >= 0; i--) send_bit(SPAT[i]);
        send_hdr(8'h0A, 8'h00, 16'h0042, 1'b0);
        chk(!hdr_ready_o, "R8", "bits ignored after failure", hdr_ready_o, 0);
        repeat (10) @(negedge clk);
        chk(crc_err_o, "R9", "crc error sticky", crc_err_o, 1);
        clear_errs();
        chk(!crc_err_o, "R9", "crc error cleared", crc_err_o, 0);

        // R4 long budget
        long_limit_i = 16'd40;
        short_limit_i = 16'd24;
        pulse_ready();
        for (int i = 0; i < 39; i++) send_bit(1'b1);
        chk(!sfd_tmo_o, "R4", "no timeout before long limit", sfd_tmo_o, 0);
        // R13 idle cycles do not advance the budget
        repeat (100) @(negedge clk);
        chk(!sfd_tmo_o, "R13", "idle does not count", sfd_tmo_o, 0);
        send_bit(1'b1);
        chk(sfd_tmo_o, "R4", "timeout at long limit", sfd_tmo_o, 1);
        clear_errs();

        // R4 short budget
        pulse_ready();
        for (int i = 0; i < 23; i++) send_bit(1'b0);
        chk(!sfd_tmo_o, "R4", "no timeout before short limit", sfd_tmo_o, 0);
        send_bit(1'b0);
        chk(sfd_tmo_o, "R4", "timeout at short limit", sfd_tmo_o, 1);
        // R1 delimiter after timeout is not taken
        for (int i = 15; i >= 0; i--) send_bit(SPAT[i]);
        send_hdr(8'h14, 8'h00, 16'h0001, 1'b0);
        chk(!hdr_ready_o, "R1", "no ready after timeout", hdr_ready_o, 0);
        clear_errs();
        chk(!sfd_tmo_o, "R9", "timeout cleared", sfd_tmo_o, 0);

        // random packets
        long_limit_i = 16'd300;
        short_limit_i = 16'd300;
        use_gaps = 1'b1;
        for (int n = 0; n < 40; n++) begin
            bit shrt = 1'($urandom % 2);
            bit bad = (($urandom % 5) == 0);
            logic [7:0] sig;
            logic [7:0] svc = 8'($urandom);
            logic [15:0] len = 16'($urandom);
            case ($urandom % 5)
                0: sig = 8'h0A;
                1: sig = 8'h14;
                2: sig = 8'h37;
                3: sig = 8'h6E;
                default: sig = 8'($urandom);
            endcase
            send_packet(shrt, 10 + int'($urandom % 150), sig, svc, len, bad);
            if (bad) begin
                chk(crc_err_o && !hdr_ready_o, "R8", "random bad header",
                    {crc_err_o, hdr_ready_o}, 2'b10);
                clear_errs();
            end else begin
                chk(hdr_ready_o && !crc_err_o, "R6", "random good header",
                    {hdr_ready_o, crc_err_o}, 2'b10);
                chk(short_mode_o == shrt, "R3", "random mode", short_mode_o, shrt);
                chk(length_o == len && service_o == svc, "R5", "random fields",
                    {length_o, service_o}, {len, svc});
                chk(rate_code_o == ref_rate(sig), "R10", "random rate",
                    rate_code_o, ref_rate(sig));
                chk(len_ext_o == svc[7] && locked_osc_o == svc[2], "R11",
                    "random service flags", {len_ext_o, locked_osc_o}, {svc[7], svc[2]});
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule